// File: doc/BRIEF.md
# Indexed Colour Palette Loader

This block holds a 256-entry colour lookup table of 24-bit entries, with 8 bits each for red, green and blue. A host loads it over a byte-wide register bus with three targets: an address register, a palette data port and a control data port. To load an entry, the host writes the entry index to the address register. It then writes three bytes to the palette data port, red first, then green, then blue. The block gathers the bytes and stores the full entry only when the blue byte arrives. After each stored entry the index steps forward by one, so a run of entries can be streamed after a single address write.

The address register is also the pointer for a small bank of indirect control registers. Writing a value to the control data port loads the control register whose number is held in the address register. Four register numbers are recognised: 0x10, 0x11, 0x20 and 0x21. On the display side, an 8-bit pixel index is looked up every cycle and the colour comes out of a register one cycle later.

Top module: `cpal_top`

## Requirements
- R1: While reset is high, and in the first cycle after it, `pix_rgb` reads 0, `ctl_regs` reads 0, and the channel sequence is set to red with the index at 0.
- R2: A bus write is a cycle with `bus_we` high. `bus_sel` picks the target: 0 is the address register, 1 is the palette data port, 2 is the control data port. After an address write of N and palette writes of bytes r, g and b, entry N holds r in bits 23:16, g in bits 15:8 and b in bits 7:0.
- R3: An entry does not change until the third (blue) palette byte of a triple is written. After only the red and green bytes, a lookup still returns the previous contents.
- R4: An address write resets the channel sequence to red, and any red or green byte already received is discarded.
- R5: Each stored triple advances the index by one, so the next triple goes to the next entry without a new address write. Index 255 wraps to 0.
- R6: `pix_rgb` shows the entry for the `pix_idx` value sampled at a rising clock edge. It appears after that edge and holds until the next one, which gives one cycle of latency.
- R7: A control data write while the address register holds 0x10, 0x11, 0x20 or 0x21 loads the byte into `ctl_regs` bits [7:0], [15:8], [23:16] or [31:24], in that order.
- R8: A control data write while the address register holds any other number leaves `ctl_regs` unchanged. No control data write changes the index or the channel sequence.
- R9: A write with `bus_sel` = 3, or a cycle with `bus_we` low, changes neither the palette, the channel sequence nor `ctl_regs`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Bus write strobe, one write per cycle |
| bus_sel | input | 2 | Write target: 0 address, 1 palette data, 2 control data, 3 none |
| bus_wdata | input | 8 | Write data byte |
| pix_idx | input | 8 | Pixel index to look up |
| pix_rgb | output | 24 | Registered colour {red, green, blue} |
| ctl_regs | output | 32 | Indirect control registers 0x21, 0x20, 0x11, 0x10, from the top byte down |

## Verification
On every cycle, the assertions check the following:
- the reset values;
- that an address write returns the channel sequence to red;
- that every stored entry moves the index up by exactly one;
- that control writes load the addressed byte and leave other bytes, the index and the channel sequence alone.

Other behaviour can only be shown by the bench's scenarios:
- the colour that lands in each entry;
- that a partial triple leaves an entry untouched;
- the one-cycle lookup latency;
- the wrap of the index from 255 to 0.

The bench loads every entry with a computed pattern and reads each one back through the pixel port.

// File: rtl/cpal_pkg.sv
package cpal_pkg;
  localparam int BYTE_W  = 8;
  localparam int RGB_W   = 3 * BYTE_W;
  localparam int NUM_CTL = 4;

  // Recognised indirect register numbers; slot order sets the byte lane in ctl_regs.
  localparam logic [BYTE_W-1:0] CTL_ID [NUM_CTL] = '{8'h10, 8'h11, 8'h20, 8'h21};

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PAL  = 2'd1,
    SEL_CTL  = 2'd2,
    SEL_NONE = 2'd3
  } bus_sel_e;

  typedef enum logic [1:0] {
    CH_RED   = 2'd0,
    CH_GREEN = 2'd1,
    CH_BLUE  = 2'd2
  } chan_e;
endpackage

// File: rtl/cpal_seq.sv
module cpal_seq
  import cpal_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [1:0]        bus_sel,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] idx_q,
  output chan_e             chan_q,
  output logic              ram_we,
  output logic [IDX_W-1:0]  ram_waddr,
  output logic [RGB_W-1:0]  ram_wdata,
  output logic              ctl_we
);
  bus_sel_e          sel;
  logic [BYTE_W-1:0] red_q, grn_q;
  logic              pal_wr, addr_wr, in_range;

  assign sel      = bus_sel_e'(bus_sel);
  assign addr_wr  = bus_we && (sel == SEL_ADDR);
  assign pal_wr   = bus_we && (sel == SEL_PAL);
  assign ctl_we   = bus_we && (sel == SEL_CTL);
  assign in_range = (idx_q <= BYTE_W'(DEPTH - 1));

  // Commit only on the blue byte, and only for an index inside the table.
  assign ram_we    = pal_wr && (chan_q == CH_BLUE) && in_range;
  assign ram_waddr = idx_q[IDX_W-1:0];
  assign ram_wdata = {red_q, grn_q, bus_wdata};

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      chan_q <= CH_RED;
      red_q  <= '0;
      grn_q  <= '0;
    end else if (addr_wr) begin
      idx_q  <= bus_wdata;
      chan_q <= CH_RED;
    end else if (pal_wr) begin
      unique case (chan_q)
        CH_RED: begin
          red_q  <= bus_wdata;
          chan_q <= CH_GREEN;
        end
        CH_GREEN: begin
          grn_q  <= bus_wdata;
          chan_q <= CH_BLUE;
        end
        default: begin
          chan_q <= CH_RED;
          idx_q  <= idx_q + 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/cpal_ram.sv
module cpal_ram
  import cpal_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [RGB_W-1:0] wdata,
  input  logic [IDX_W-1:0] raddr,
  output logic [RGB_W-1:0] rdata
);
  logic [RGB_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // Output register with synchronous reset, as block RAM provides.
  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[raddr];
  end
endmodule

// File: rtl/cpal_ctlbank.sv
module cpal_ctlbank
  import cpal_pkg::*;
#(
  parameter int NUM = NUM_CTL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [BYTE_W-1:0]     num,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [NUM*BYTE_W-1:0] regs
);
  logic [NUM-1:0] hit;

  for (genvar g = 0; g < NUM; g++) begin : g_match
    assign hit[g] = (num == CTL_ID[g]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      regs <= '0;
    end else if (we) begin
      for (int s = 0; s < NUM; s++) begin
        if (hit[s]) regs[s*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end
endmodule

// File: rtl/cpal_top.sv
module cpal_top
  import cpal_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      bus_we,
  input  logic [1:0]                bus_sel,
  input  logic [BYTE_W-1:0]         bus_wdata,
  input  logic [IDX_W-1:0]          pix_idx,
  output logic [RGB_W-1:0]          pix_rgb,
  output logic [NUM_CTL*BYTE_W-1:0] ctl_regs
);
  logic [BYTE_W-1:0] idx_q;
  chan_e             chan_q;
  logic              ram_we, ctl_we;
  logic [IDX_W-1:0]  ram_waddr;
  logic [RGB_W-1:0]  ram_wdata;

  cpal_seq #(.DEPTH(DEPTH)) u_seq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .idx_q(idx_q), .chan_q(chan_q),
    .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ctl_we(ctl_we)
  );

  cpal_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .rst(rst), .we(ram_we), .waddr(ram_waddr),
    .wdata(ram_wdata), .raddr(pix_idx), .rdata(pix_rgb)
  );

  cpal_ctlbank #(.NUM(NUM_CTL)) u_ctl (
    .clk(clk), .rst(rst), .we(ctl_we), .num(idx_q),
    .wdata(bus_wdata), .regs(ctl_regs)
  );
endmodule

// File: rtl/cpal_chk.sv
module cpal_chk
  import cpal_pkg::*;
(
  input logic                      clk,
  input logic                      rst,
  input logic                      bus_we,
  input logic [1:0]                bus_sel,
  input logic [BYTE_W-1:0]         bus_wdata,
  input logic [RGB_W-1:0]          pix_rgb,
  input logic [NUM_CTL*BYTE_W-1:0] ctl_regs,
  input logic [BYTE_W-1:0]         idx_q,
  input logic [1:0]                chan_q,
  input logic                      ram_we
);
  logic ctl_wr, addr_wr, ctl_known;
  assign ctl_wr  = bus_we && (bus_sel == 2'd2);
  assign addr_wr = bus_we && (bus_sel == 2'd0);
  always_comb begin
    ctl_known = 1'b0;
    for (int s = 0; s < NUM_CTL; s++) if (idx_q == CTL_ID[s]) ctl_known = 1'b1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (pix_rgb == '0 && ctl_regs == '0 && chan_q == 2'd0 && idx_q == '0));

  assert_addr_restart_R4: assert property (@(posedge clk) disable iff (rst)
    addr_wr |=> (chan_q == 2'd0 && idx_q == $past(bus_wdata)));

  assert_commit_advance_R5: assert property (@(posedge clk) disable iff (rst)
    ram_we |=> (chan_q == 2'd0 && idx_q == $past(idx_q) + 8'd1));

  assert_ctl_keeps_seq_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ($stable(idx_q) && $stable(chan_q)));

  assert_ctl_unknown_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && !ctl_known) |=> $stable(ctl_regs));

  assert_ctl_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !ctl_wr |=> $stable(ctl_regs));

  for (genvar g = 0; g < NUM_CTL; g++) begin : g_lane
    assert_ctl_load_R7: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && idx_q == CTL_ID[g]) |=> (ctl_regs[g*BYTE_W +: BYTE_W] == $past(bus_wdata)));
  end
endmodule

bind cpal_top cpal_chk u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
  .bus_wdata(bus_wdata), .pix_rgb(pix_rgb), .ctl_regs(ctl_regs),
  .idx_q(idx_q), .chan_q(chan_q), .ram_we(ram_we)
);

// File: tb/tb_cpal_top.sv
module tb_cpal_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_we = 1'b0;
  logic [1:0]  bus_sel = 2'd3;
  logic [7:0]  bus_wdata = 8'd0;
  logic [7:0]  pix_idx = 8'd0;
  logic [23:0] pix_rgb;
  logic [31:0] ctl_regs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [23:0] expv [256];

  always #2.5 clk = ~clk;

  cpal_top dut (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_sel(bus_sel),
    .bus_wdata(bus_wdata), .pix_idx(pix_idx), .pix_rgb(pix_rgb),
    .ctl_regs(ctl_regs)
  );

  function automatic logic [23:0] colour(int i, int s);
    return {8'(i + s), 8'(~i), 8'(i * 7 + 3 + s)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All bus tasks are entered just after a falling edge.
  task automatic wr(logic [1:0] s, logic [7:0] d);
    bus_we = 1'b1; bus_sel = s; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_sel = 2'd3;
  endtask

  task automatic triple(logic [23:0] c);
    wr(2'd1, c[23:16]); wr(2'd1, c[15:8]); wr(2'd1, c[7:0]);
  endtask

  task automatic look(string req, logic [7:0] i);
    pix_idx = i;
    @(negedge clk);
    chk(req, {8'd0, pix_rgb}, {8'd0, expv[i]});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rgb", {8'd0, pix_rgb}, 32'd0);
    chk("R1 ctl", ctl_regs, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 ctl after", ctl_regs, 32'd0);

    // R2/R5: one address write, then all 256 entries streamed with auto-increment.
    wr(2'd0, 8'd0);
    for (int i = 0; i < 256; i++) begin
      expv[i] = colour(i, 0);
      triple(expv[i]);
    end
    for (int i = 0; i < 256; i++) look("R2", 8'(i));

    // R5: index wrapped 255 -> 0, so the next triple lands in entry 0.
    expv[0] = colour(0, 91);
    triple(expv[0]);
    look("R5 wrap", 8'd0);
    look("R5 neighbour", 8'd1);

    // R3: partial triple leaves entry untouched until blue.
    wr(2'd0, 8'd10);
    wr(2'd1, 8'h5A); wr(2'd1, 8'hC7);
    look("R3 partial", 8'd10);
    wr(2'd1, 8'h3C);
    expv[10] = 24'h5AC73C;
    look("R3 blue", 8'd10);

    // R4: address write discards red/green already received.
    wr(2'd0, 8'd20);
    wr(2'd1, 8'hAA); wr(2'd1, 8'hBB);
    wr(2'd0, 8'd20);
    triple(24'h010203);
    expv[20] = 24'h010203;
    look("R4 restart", 8'd20);
    look("R4 next", 8'd21);

    // R6: output follows the index one edge later.
    pix_idx = 8'd5;
    @(negedge clk);
    chk("R6 hold", {8'd0, pix_rgb}, {8'd0, expv[5]});
    pix_idx = 8'd6;
    #1;
    chk("R6 before edge", {8'd0, pix_rgb}, {8'd0, expv[5]});
    @(negedge clk);
    chk("R6 after edge", {8'd0, pix_rgb}, {8'd0, expv[6]});

    // R7: the four recognised register numbers and their byte lanes.
    wr(2'd0, 8'h10); wr(2'd2, 8'h11);
    wr(2'd0, 8'h11); wr(2'd2, 8'h22);
    wr(2'd0, 8'h20); wr(2'd2, 8'h33);
    wr(2'd0, 8'h21); wr(2'd2, 8'h44);
    chk("R7 lanes", ctl_regs, 32'h44332211);
    wr(2'd0, 8'h20); wr(2'd2, 8'h9E);
    chk("R7 rewrite", ctl_regs, 32'h449E2211);

    // R8: unknown register numbers ignored.
    wr(2'd0, 8'h30); wr(2'd2, 8'hFF);
    chk("R8 num30", ctl_regs, 32'h449E2211);
    wr(2'd0, 8'h12); wr(2'd2, 8'hFF);
    chk("R8 num12", ctl_regs, 32'h449E2211);

    // R8: control write mid-triple does not disturb index or channel.
    wr(2'd0, 8'd40);
    wr(2'd1, 8'h0D);
    wr(2'd2, 8'h77);
    chk("R8 ctl mid", ctl_regs, 32'h449E2211);
    wr(2'd1, 8'h0E); wr(2'd1, 8'h0F);
    expv[40] = 24'h0D0E0F;
    look("R8 triple", 8'd40);

    // R9: sel 3 writes and idle strobes ignored mid-triple.
    wr(2'd0, 8'd50);
    wr(2'd1, 8'h21);
    wr(2'd3, 8'hEE);
    bus_sel = 2'd1; bus_wdata = 8'hDD;
    @(negedge clk);
    bus_sel = 2'd3;
    wr(2'd1, 8'h22);
    look("R9 partial", 8'd50);
    wr(2'd1, 8'h23);
    expv[50] = 24'h212223;
    look("R9 triple", 8'd50);
    look("R9 next", 8'd51);
    chk("R9 ctl", ctl_regs, 32'h449E2211);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule